// File: doc/BRIEF.md
# Real-Time Clock Time-of-Day and Alarm Engine

This block keeps calendar time for a real-time clock: seconds, minutes, hours, day of week, day of month, month, two-digit year and century. A prescaler counts a one-cycle enable from the time base and, once per second, moves the whole calendar forward by one second. Every field can be held in plain binary or in packed BCD. Hours can be held in 24-hour form or in 12-hour form with a PM flag.

Software loads the time and three alarm fields through a simple write port. It controls the engine through a three-bit divider select, a freeze bit and two interrupt enables. The engine reports an update-in-progress status level shortly before each rollover. After every update it emits one-cycle pulses for the update-ended and alarm events, plus an interrupt-request pulse for the events whose enable is set. Latching those pulses into a readable flag register, and decoding the bus, are left to the surrounding logic.

Top module: `rtc_tod_engine`

## Requirements
- R1: With `set_i` low and `div_sel_i` at 3'b010 or lower, an update occurs once every `TICKS_PER_SEC` enabled time-base ticks. Any other select value that is not a divider hold produces no updates.
- R2: While `div_sel_i[2:1]` is 2'b11, the divider is held, there are no updates and the status bit is low. After release, the first update occurs `TICKS_PER_SEC/2` ticks later.
- R3: `uip_o` is high during the last `UIP_TICKS` ticks before each update and low at all other times.
- R4: While `set_i` is high, the time is not advanced, no update pulse is produced and `uip_o` is low. After `set_i` is cleared, counting resumes from the values written during the freeze.
- R5: With `bin_mode_i` = 1 fields are stored in binary. With `bin_mode_i` = 0 they are stored in packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R6: With `hr24_i` = 1, hours run from 0 to 23. With `hr24_i` = 0, hours run from 1 to 12 in bits 6:0, bit 7 is set for PM, and both midnight and noon are held as 12.
- R7: Seconds and minutes wrap from 59 to 0 and carry into the next field. Hours wrap from 23 to 0 and carry into the day. Day of week runs 1 to 7 and wraps from 7 to 1.
- R8: Day of month wraps to 1 after the length of the month: 30 for months 4, 6, 9 and 11, 31 for the other long months, and for February 29 when the year is divisible by 4, else 28. Month wraps from 12 to 1. Year wraps from 99 to 0 and increments the century.
- R9: Each update produces a one-cycle `upd_flag_o` pulse in the cycle in which the new time first appears on the outputs.
- R10: `alm_flag_o` pulses together with `upd_flag_o` when each of the three alarm fields either equals the new time field or has bits 7:6 = 2'b11, which matches any value.
- R11: `irq_o` pulses with an update when `uie_i` is set, or when an alarm matches and `aie_i` is set. Otherwise it stays low.
- R12: A write with `wr_en_i` loads `wr_data_i` into the field at `wr_addr_i` at the next clock edge. The addresses are: seconds 0, minutes 1, hours 2, day of week 3, day of month 4, month 5, year 6, century 7, alarm seconds 8, alarm minutes 9, alarm hours 10. Time fields change only through an update or such a write, and alarm writes leave the time unchanged.
- R13: After reset, the time reads 00:00:00, with day of week 1, day 1, month 1, year 0 and century 0, and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base enable, one cycle per oscillator period |
| div_sel_i | input | 3 | Divider select; 11x holds the divider, 010 or lower runs it |
| set_i | input | 1 | Freeze updates for time loading |
| bin_mode_i | input | 1 | 1 = binary storage, 0 = BCD |
| hr24_i | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| uie_i | input | 1 | Update event interrupt enable |
| aie_i | input | 1 | Alarm event interrupt enable |
| wr_en_i | input | 1 | Field write strobe |
| wr_addr_i | input | 4 | Field write address |
| wr_data_i | input | 8 | Field write data |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| wday_o | output | 8 | Day of week |
| mday_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year within the century |
| century_o | output | 8 | Century |
| uip_o | output | 1 | Update in progress |
| upd_flag_o | output | 1 | Update-ended pulse |
| alm_flag_o | output | 1 | Alarm pulse |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The bench builds the engine with `TICKS_PER_SEC` = 16 and `UIP_TICKS` = 2. A full second then lasts a handful of clocks, so every end-of-month rollover in both a leap and a non-leap year can be swept in binary and in BCD. The same setting allows every hour of the day to be swept in all four combinations of storage mode and hour format. With these values the half-second start and the width of the status window become exact cycle counts that are checked on every update.

// File: rtl/rtc_tod_pkg.sv
package rtc_tod_pkg;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] mday;
    logic [7:0] month;
    logic [7:0] year;
    logic [7:0] cent;
  } tod_t;

  localparam logic [3:0] A_SEC      = 4'd0;
  localparam logic [3:0] A_MIN      = 4'd1;
  localparam logic [3:0] A_HOUR     = 4'd2;
  localparam logic [3:0] A_WDAY     = 4'd3;
  localparam logic [3:0] A_MDAY     = 4'd4;
  localparam logic [3:0] A_MONTH    = 4'd5;
  localparam logic [3:0] A_YEAR     = 4'd6;
  localparam logic [3:0] A_CENT     = 4'd7;
  localparam logic [3:0] A_ALM_BASE = 4'd8;

  localparam logic [1:0] ALM_ANY = 2'b11;

  function automatic logic [6:0] reg2bin(input logic [7:0] v, input logic bin);
    if (bin) return v[6:0];
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] bin2reg(input logic [6:0] b, input logic bin);
    logic [6:0] tens, units;
    tens  = b / 7'd10;
    units = b % 7'd10;
    if (bin) return {1'b0, b};
    return {tens[3:0], units[3:0]};
  endfunction

  function automatic logic [4:0] hour_to_h24(input logic [7:0] v, input logic bin,
                                              input logic hr24);
    logic [6:0] h;
    h = reg2bin({1'b0, v[6:0]}, bin);
    if (hr24) return h[4:0];
    if (h == 7'd12) h = 7'd0;
    return h[4:0] + (v[7] ? 5'd12 : 5'd0);
  endfunction

  function automatic logic [7:0] h24_to_reg(input logic [4:0] h, input logic bin,
                                             input logic hr24);
    logic [4:0] h12;
    if (hr24) return bin2reg({2'b00, h}, bin);
    if (h == 5'd0)       h12 = 5'd12;
    else if (h > 5'd12)  h12 = h - 5'd12;
    else                 h12 = h;
    return bin2reg({2'b00, h12}, bin) | {(h >= 5'd12), 7'b0};
  endfunction

  function automatic logic [6:0] month_days(input logic [6:0] mon, input logic [6:0] yr);
    case (mon)
      7'd2:                      return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
      default:                   return 7'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned UIP_TICKS     = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [2:0] div_sel_i,
  input  logic       freeze_i,
  output logic       strobe_o,
  output logic       uip_o
);
  localparam int unsigned CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST      = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] HALF      = CW'(TICKS_PER_SEC / 2);
  localparam logic [CW-1:0] UIP_START = CW'(TICKS_PER_SEC - UIP_TICKS);

  logic [CW-1:0] cnt_q;
  logic          div_hold, div_run, wrap;

  assign div_hold = (div_sel_i[2:1] == 2'b11);
  assign div_run  = (div_sel_i <= 3'b010);
  assign wrap     = tick_i & div_run & (cnt_q == LAST);

  // held divider restarts at mid-second so the first update lands half a second later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= HALF;
    else if (div_hold)          cnt_q <= HALF;
    else if (tick_i && div_run) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign strobe_o = wrap & ~freeze_i;
  assign uip_o    = div_run & ~freeze_i & (cnt_q >= UIP_START);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_tod_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strobe_i,
  input  logic       bin_i,
  input  logic       hr24_i,
  input  logic       wr_en_i,
  input  logic [3:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output tod_t       tod_o,
  output tod_t       adv_o
);
  tod_t       tod_q, tod_d, adv;
  logic [6:0] s_b, m_b, w_b, d_b, mo_b, y_b, c_b, mlen;
  logic [4:0] h_b, h_n;
  logic [6:0] s_n, m_n, w_n, d_n, mo_n, y_n, c_n;
  logic       c_min, c_hr, c_day, c_mon, c_yr, c_cen;

  always_comb begin
    s_b  = reg2bin(tod_q.sec, bin_i);
    m_b  = reg2bin(tod_q.min, bin_i);
    h_b  = hour_to_h24(tod_q.hour, bin_i, hr24_i);
    w_b  = reg2bin(tod_q.wday, bin_i);
    d_b  = reg2bin(tod_q.mday, bin_i);
    mo_b = reg2bin(tod_q.month, bin_i);
    y_b  = reg2bin(tod_q.year, bin_i);
    c_b  = reg2bin(tod_q.cent, bin_i);
    mlen = month_days(mo_b, y_b);

    c_min = (s_b >= 7'd59);
    s_n   = c_min ? 7'd0 : s_b + 7'd1;
    c_hr  = c_min & (m_b >= 7'd59);
    m_n   = c_min ? ((m_b >= 7'd59) ? 7'd0 : m_b + 7'd1) : m_b;
    c_day = c_hr & (h_b >= 5'd23);
    h_n   = c_hr ? ((h_b >= 5'd23) ? 5'd0 : h_b + 5'd1) : h_b;
    w_n   = c_day ? ((w_b >= 7'd7) ? 7'd1 : w_b + 7'd1) : w_b;
    c_mon = c_day & (d_b >= mlen);
    d_n   = c_day ? (c_mon ? 7'd1 : d_b + 7'd1) : d_b;
    c_yr  = c_mon & (mo_b >= 7'd12);
    mo_n  = c_mon ? (c_yr ? 7'd1 : mo_b + 7'd1) : mo_b;
    c_cen = c_yr & (y_b >= 7'd99);
    y_n   = c_yr ? (c_cen ? 7'd0 : y_b + 7'd1) : y_b;
    c_n   = c_cen ? ((c_b >= 7'd99) ? 7'd0 : c_b + 7'd1) : c_b;

    adv.sec   = bin2reg(s_n, bin_i);
    adv.min   = bin2reg(m_n, bin_i);
    adv.hour  = h24_to_reg(h_n, bin_i, hr24_i);
    adv.wday  = bin2reg(w_n, bin_i);
    adv.mday  = bin2reg(d_n, bin_i);
    adv.month = bin2reg(mo_n, bin_i);
    adv.year  = bin2reg(y_n, bin_i);
    adv.cent  = bin2reg(c_n, bin_i);
  end

  // a write overrides the advanced value of its own field
  always_comb begin
    tod_d = strobe_i ? adv : tod_q;
    if (wr_en_i) begin
      case (wr_addr_i)
        A_SEC:   tod_d.sec   = wr_data_i;
        A_MIN:   tod_d.min   = wr_data_i;
        A_HOUR:  tod_d.hour  = wr_data_i;
        A_WDAY:  tod_d.wday  = wr_data_i;
        A_MDAY:  tod_d.mday  = wr_data_i;
        A_MONTH: tod_d.month = wr_data_i;
        A_YEAR:  tod_d.year  = wr_data_i;
        A_CENT:  tod_d.cent  = wr_data_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tod_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h01, mday: 8'h01,
                 month: 8'h01, year: 8'h00, cent: 8'h00};
    end else begin
      tod_q <= tod_d;
    end
  end

  assign tod_o = tod_q;
  assign adv_o = adv;

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_tod_pkg::*;
#(
  parameter int unsigned NUM_ALM = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [3:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  tod_t       cand_i,
  output logic       match_o
);
  logic [NUM_ALM-1:0][7:0] cand_f;
  logic [NUM_ALM-1:0]      hit;

  assign cand_f[0] = cand_i.sec;
  assign cand_f[1] = cand_i.min;
  assign cand_f[2] = cand_i.hour;

  for (genvar i = 0; i < NUM_ALM; i++) begin : g_alm
    localparam logic [3:0] ADDR = A_ALM_BASE + 4'(i);
    logic [7:0] alm_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           alm_q <= 8'h00;
      else if (wr_en_i && wr_addr_i == ADDR) alm_q <= wr_data_i;
    end

    assign hit[i] = (alm_q[7:6] == ALM_ANY) | (alm_q == cand_f[i]);
  end

  assign match_o = &hit;

endmodule

// File: rtl/rtc_tod_engine.sv
module rtc_tod_engine
  import rtc_tod_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned UIP_TICKS     = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [2:0] div_sel_i,
  input  logic       set_i,
  input  logic       bin_mode_i,
  input  logic       hr24_i,
  input  logic       uie_i,
  input  logic       aie_i,
  input  logic       wr_en_i,
  input  logic [3:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic [7:0] century_o,
  output logic       uip_o,
  output logic       upd_flag_o,
  output logic       alm_flag_o,
  output logic       irq_o
);
  logic strobe, match;
  tod_t tod, adv;
  logic upd_q, alm_q, irq_q;

  rtc_prescaler #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .UIP_TICKS     (UIP_TICKS)
  ) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .div_sel_i (div_sel_i),
    .freeze_i  (set_i),
    .strobe_o  (strobe),
    .uip_o     (uip_o)
  );

  rtc_calendar u_cal (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (strobe),
    .bin_i     (bin_mode_i),
    .hr24_i    (hr24_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .tod_o     (tod),
    .adv_o     (adv)
  );

  // compare against the time about to be loaded, not the outgoing one
  rtc_alarm_cmp #(.NUM_ALM(3)) u_alm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .cand_i    (adv),
    .match_o   (match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q <= 1'b0;
      alm_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      upd_q <= strobe;
      alm_q <= strobe & match;
      irq_q <= strobe & (uie_i | (match & aie_i));
    end
  end

  assign sec_o      = tod.sec;
  assign min_o      = tod.min;
  assign hour_o     = tod.hour;
  assign wday_o     = tod.wday;
  assign mday_o     = tod.mday;
  assign month_o    = tod.month;
  assign year_o     = tod.year;
  assign century_o  = tod.cent;
  assign upd_flag_o = upd_q;
  assign alm_flag_o = alm_q;
  assign irq_o      = irq_q;

endmodule

// File: rtl/rtc_tod_engine_chk.sv
module rtc_tod_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] div_sel_i,
  input logic       set_i,
  input logic       uie_i,
  input logic       aie_i,
  input logic       wr_en_i,
  input logic [7:0] sec_o,
  input logic       uip_o,
  input logic       upd_flag_o,
  input logic       alm_flag_o,
  input logic       irq_o
);
  // R4
  set_clears_uip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> !uip_o);
  // R4
  set_blocks_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> !upd_flag_o);
  // R2
  hold_no_uip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_sel_i[2:1] == 2'b11) |-> !uip_o);
  // R2
  hold_no_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_sel_i[2:1] == 2'b11) |=> !upd_flag_o);
  // R9
  upd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_flag_o |=> !upd_flag_o);
  // R10
  alm_with_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alm_flag_o |-> upd_flag_o);
  // R11
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((upd_flag_o && $past(uie_i)) || (alm_flag_o && $past(aie_i))));
  // R12
  sec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (upd_flag_o || $stable(sec_o)));
endmodule

bind rtc_tod_engine rtc_tod_engine_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .div_sel_i  (div_sel_i),
  .set_i      (set_i),
  .uie_i      (uie_i),
  .aie_i      (aie_i),
  .wr_en_i    (wr_en_i),
  .sec_o      (sec_o),
  .uip_o      (uip_o),
  .upd_flag_o (upd_flag_o),
  .alm_flag_o (alm_flag_o),
  .irq_o      (irq_o)
);

// File: tb/rtc_tod_engine_tb.sv
module rtc_tod_engine_tb;
  localparam int TICKS = 16;
  localparam int UIPN  = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic [2:0] div_sel_i = 3'b110;
  logic       set_i = 1'b0;
  logic       bin_mode_i = 1'b1;
  logic       hr24_i = 1'b1;
  logic       uie_i = 1'b0;
  logic       aie_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, month_o, year_o, century_o;
  logic       uip_o, upd_flag_o, alm_flag_o, irq_o;

  int n_checks = 0;
  int n_err = 0;
  int cyc, uipc;
  bit seen, got_alm, got_irq;

  always #10 clk_i = ~clk_i;

  rtc_tod_engine #(.TICKS_PER_SEC(TICKS), .UIP_TICKS(UIPN)) u_dut (.*);

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] enc(input int v);
    if (bin_mode_i) return 8'(v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] enc_hour(input int h);
    int h12;
    if (hr24_i) return enc(h);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return enc(h12) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [63:0] enc_tod(input int s, m, h, w, d, mo, y, c);
    return {enc(s), enc(m), enc_hour(h), enc(w), enc(d), enc(mo), enc(y), enc(c)};
  endfunction

  function automatic logic [63:0] tod_vec();
    return {sec_o, min_o, hour_o, wday_o, mday_o, month_o, year_o, century_o};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic load_time(input int s, m, h, w, d, mo, y, c);
    wr(4'd0, enc(s)); wr(4'd1, enc(m)); wr(4'd2, enc_hour(h)); wr(4'd3, enc(w));
    wr(4'd4, enc(d)); wr(4'd5, enc(mo)); wr(4'd6, enc(y)); wr(4'd7, enc(c));
  endtask

  task automatic wait_upd(input int limit);
    cyc = 0; uipc = 0; seen = 0; got_alm = 0; got_irq = 0;
    while (!seen && cyc < limit) begin
      @(negedge clk_i);
      cyc++;
      if (uip_o) uipc++;
      if (upd_flag_o) begin
        seen = 1; got_alm = alm_flag_o; got_irq = irq_o;
      end
    end
  endtask

  task automatic release_and_wait();
    @(negedge clk_i);
    div_sel_i = 3'b010;
    wait_upd(4 * TICKS);
  endtask

  task automatic hold();
    div_sel_i = 3'b110;
    @(negedge clk_i);
  endtask

  // load a time, run one update, compare against the arithmetic successor
  task automatic step_case(input string req, input int s, m, h, w, d, mo, y, c);
    int es, em, eh, ew, ed, emo, ey, ec;
    load_time(s, m, h, w, d, mo, y, c);
    release_and_wait();
    es = s + 1; em = m; eh = h; ew = w; ed = d; emo = mo; ey = y; ec = c;
    if (es == 60) begin es = 0; em++; end
    if (em == 60) begin em = 0; eh++; end
    if (eh == 24) begin
      eh = 0; ew = (ew == 7) ? 1 : ew + 1; ed++;
      if (ed > mdays(mo, y)) begin ed = 1; emo++; end
      if (emo == 13) begin emo = 1; ey++; end
      if (ey == 100) begin ey = 0; ec = (ec == 99) ? 0 : ec + 1; end
    end
    check({req, " upd seen"}, 64'(seen), 64'd1);
    check({req, " time"}, tod_vec(), enc_tod(es, em, eh, ew, ed, emo, ey, ec));
    check("R2 half-second start", 64'(cyc), 64'(TICKS / 2));
    check("R3 uip width", 64'(uipc), 64'(UIPN));
    hold();
  endtask

  task automatic alarm_case(input string req, input logic [7:0] as, am, ah,
                            input bit exp_m, input bit u, input bit a, input bit exp_irq);
    bin_mode_i = 1; hr24_i = 1; uie_i = u; aie_i = a;
    load_time(30, 20, 10, 2, 5, 6, 24, 20);
    wr(4'd8, as); wr(4'd9, am); wr(4'd10, ah);
    release_and_wait();
    check({req, " alarm"}, 64'(got_alm), 64'(exp_m));
    check("R11 irq", 64'(got_irq), 64'(exp_irq));
    hold();
    uie_i = 0; aie_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL R1 watchdog got=hung exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [63:0] t0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R13 reset state
    check("R13 reset time", tod_vec(), {8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00});
    check("R13 reset pulses", 64'({uip_o, upd_flag_o, alm_flag_o, irq_o}), 64'd0);

    // R8 R7 R5: month-end sweep, both storage modes, leap and non-leap year
    for (int b = 0; b < 2; b++) begin
      bin_mode_i = b[0]; hr24_i = 1;
      for (int yi = 0; yi < 2; yi++) begin
        for (int mo = 1; mo <= 12; mo++) begin
          step_case(b ? "R8 R5 month-end bin" : "R8 R5 month-end bcd",
                    59, 59, 23, 7, mdays(mo, 23 + yi), mo, 23 + yi, 20);
        end
      end
      step_case("R8 century carry", 59, 59, 23, 2, 31, 12, 99, 19);
      step_case("R8 leap Feb 28", 59, 59, 23, 1, 28, 2, 24, 20);
      step_case("R7 minute carry", 59, 14, 5, 3, 10, 5, 24, 20);
      step_case("R7 second", 7, 14, 5, 3, 10, 5, 24, 20);
    end

    // R6 R5: every hour, all four format combinations
    for (int b = 0; b < 2; b++) begin
      for (int f = 0; f < 2; f++) begin
        bin_mode_i = b[0]; hr24_i = f[0];
        for (int h = 0; h < 24; h++) begin
          step_case(f ? "R6 hour 24h" : "R6 hour 12h", 59, 59, h, 3, 10, 5, 24, 20);
        end
      end
    end

    // R6: raw 12-hour encodings of midnight and noon
    bin_mode_i = 0; hr24_i = 0;
    load_time(0, 0, 0, 1, 1, 1, 0, 0);
    check("R6 midnight is 12 AM", 64'(hour_o), 64'h12);
    load_time(0, 0, 12, 1, 1, 1, 0, 0);
    check("R6 noon is 12 PM", 64'(hour_o), 64'h92);

    // R1: steady interval between updates
    bin_mode_i = 1; hr24_i = 1;
    load_time(0, 0, 0, 1, 1, 1, 0, 0);
    release_and_wait();
    wait_upd(4 * TICKS);
    check("R1 interval", 64'(cyc), 64'(TICKS));
    check("R1 two seconds", 64'(sec_o), 64'd2);
    // R1: select 011 neither runs nor holds
    @(negedge clk_i); div_sel_i = 3'b011;
    t0 = tod_vec();
    wait_upd(3 * TICKS);
    check("R1 stopped select no upd", 64'(seen), 64'd0);
    check("R1 stopped select time", tod_vec(), t0);
    check("R3 uip low when stopped", 64'(uipc), 64'd0);
    hold();

    // R2: divider held for several seconds
    t0 = tod_vec();
    wait_upd(3 * TICKS);
    check("R2 held no upd", 64'(seen), 64'd0);
    check("R2 held uip", 64'(uipc), 64'd0);
    check("R2 held time", tod_vec(), t0);

    // R4: freeze, load during freeze, resume
    load_time(3, 2, 1, 4, 9, 8, 30, 20);
    set_i = 1;
    @(negedge clk_i); div_sel_i = 3'b010;
    wait_upd(3 * TICKS);
    check("R4 frozen no upd", 64'(seen), 64'd0);
    check("R4 frozen uip", 64'(uipc), 64'd0);
    check("R4 frozen time", tod_vec(), enc_tod(3, 2, 1, 4, 9, 8, 30, 20));
    wr(4'd0, enc(40));
    check("R12 write while frozen", 64'(sec_o), 64'(enc(40)));
    set_i = 0;
    wait_upd(2 * TICKS);
    check("R4 resume upd", 64'(seen), 64'd1);
    check("R4 resume from written", tod_vec(), enc_tod(41, 2, 1, 4, 9, 8, 30, 20));
    hold();

    // R10 R11: alarm matching, wildcards (bits 7:6 = 11), interrupt gating
    alarm_case("R10 exact",        8'd31, 8'd20, 8'd10, 1, 0, 1, 1);
    alarm_case("R10 all any",      8'hC0, 8'hC0, 8'hC0, 1, 0, 0, 0);
    alarm_case("R10 mixed any",    8'd31, 8'hFF, 8'hC5, 1, 0, 1, 1);
    alarm_case("R10 sec mismatch", 8'd32, 8'd20, 8'd10, 0, 0, 1, 0);
    alarm_case("R10 hour mismatch",8'hC0, 8'hC0, 8'd11, 0, 1, 0, 1);
    alarm_case("R10 old time",     8'd30, 8'd20, 8'd10, 0, 0, 1, 0);

    // R12: alarm writes leave time untouched
    t0 = tod_vec();
    wr(4'd8, 8'h11); wr(4'd9, 8'h22); wr(4'd10, 8'h03);
    check("R12 alarm write time", tod_vec(), t0);

    repeat (2) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule